// File: doc/BRIEF.md
# Pipelined Burst SRAM Controller and Array

This block is a cycle-accurate control and storage model of a pipelined synchronous burst SRAM. On every rising clock edge it decodes the three chip enables, the two address strobes, the burst-advance input, the power-down input and the write enables. From these it classifies the cycle as one of the following: deselect, power-down, burst start at the external address, burst advance to the next address, or burst hold at the current address.

The burst start has two sources. The processor-side strobe always starts a read, and chip enable 1 gates it. The controller-side strobe starts a read or a write. A 2-bit burst counter steps through the four words that share the upper address bits, in linear or interleaved order. A byte-lane combiner turns the global write and the lane-write inputs into a per-lane write mask. Read data passes through a pipeline register. The bus drive enable responds to the output enable without any clock, and it is forced off in the cycle after a write edge.

Top module: `sbsram_ctrl`

## Requirements
- R1: While `pwr_dn` is high, `dq_oe` is 0 at once, no array location is written, and any open burst is closed.
- R2: With `ce_pri_n` high, `strb_cpu_n` has no effect. A low `strb_ctl_n` then gives a deselect cycle: no access, no write, and the burst closes.
- R3: With `ce_pri_n` low and either `ce_hi` low or `ce_lo_n` high, a low strobe gives a deselect cycle: no access, no write, and the bus is not driven.
- R4: With the chip selected (`ce_pri_n`=0, `ce_hi`=1, `ce_lo_n`=0) and `strb_cpu_n` low, a read burst starts at `addr`. This holds even when the write enables are active, and nothing is written.
- R5: With the chip selected, `strb_cpu_n` high and `strb_ctl_n` low, a burst starts at `addr`. It is a write of `din` on that same edge if the combined write is active, and a read otherwise. A write may follow a processor-strobe read on the next edge.
- R6: The combined write is active when `wr_all_n`=0, and then all four lanes are written. It is also active when `wr_lane_en_n`=0 and some `lane_sel_n[i]`=0, and then only those lanes are written. Lane i is bits 8i+7..8i. In every other case the cycle is a read.
- R7: When `ilv_mode` was 0 at burst start, the k-th advance accesses low bits (first+k) mod 4. Bits [5:2] stay at their start value, and the order wraps.
- R8: When `ilv_mode` was 1 at burst start, the k-th advance accesses low bits first XOR k.
- R9: With `strb_ctl_n` high, `strb_cpu_n` high or `ce_pri_n` high, and `burst_adv_n` high, the current burst address is reused for a read or a write.
- R10: Data for a read decoded at edge n appears on `dout` with `dq_oe`=1 after edge n+1, when `oe_n` is low.
- R11: `dq_oe` follows `oe_n` without a clock and is 0 while `oe_n` is high. It is also 0 in the cycle that follows a write edge.
- R12: An advance or hold cycle with no open burst (after reset, a deselect or a power-down) makes no access and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_dn | input | 1 | Power-down, active high |
| ce_pri_n | input | 1 | Primary chip enable, active low; gates the processor strobe |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Tertiary chip enable, active low |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| wr_lane_en_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | 4 | Per-lane write select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| ilv_mode | input | 1 | Burst order at start: 0 linear, 1 interleaved |
| addr | input | 6 | External word address |
| din | input | 32 | Write data |
| dout | output | 32 | Read data from the pipeline register |
| dq_oe | output | 1 | Data bus drive enable (tri-state control) |

## Verification
On every cycle, the assertions check several properties. Power-down never drives the bus or writes. A processor-strobe start never writes, and chip enable 1 blocks the controller strobe. A high output enable, or a preceding write edge, keeps the bus released. A hold never moves the burst counter, and an advance or hold with no open burst never makes an access. The data ordering can only be shown by the bench's scenarios against its own memory model: the linear and interleaved wrap, the lane-merged write contents, the one-extra-edge read latency, and the data that survives ignored writes.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  localparam int BURST_W = 2;

  typedef enum logic [2:0] {
    CYC_DESEL,
    CYC_SLEEP,
    CYC_START_CPU,
    CYC_START_CTL,
    CYC_NEXT,
    CYC_HOLD
  } cyc_e;

  // Low address bits of the k-th word of a burst.
  function automatic logic [BURST_W-1:0] burst_lo(input logic [BURST_W-1:0] first,
                                                  input logic [BURST_W-1:0] k,
                                                  input logic               ilv);
    return ilv ? (first ^ k) : (first + k);
  endfunction

  // Combined write request from the global and lane enables.
  function automatic logic write_active(input logic all_n, input logic lane_en_n,
                                        input logic any_lane);
    return !all_n || (!lane_en_n && any_lane);
  endfunction

endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
  import sbsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             pwr_dn,
  input  logic             ce_pri_n,
  input  logic             ce_hi,
  input  logic             ce_lo_n,
  input  logic             strb_cpu_n,
  input  logic             strb_ctl_n,
  input  logic             burst_adv_n,
  input  logic             wr_all_n,
  input  logic             wr_lane_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  output cyc_e             cyc,
  output logic             wr_req,
  output logic [LANES-1:0] lane_we
);

  logic chip_sel;
  logic cpu_take;

  assign chip_sel = !ce_pri_n && ce_hi && !ce_lo_n;
  assign cpu_take = !ce_pri_n && !strb_cpu_n;

  always_comb begin
    if (pwr_dn)           cyc = CYC_SLEEP;
    else if (cpu_take)    cyc = chip_sel ? CYC_START_CPU : CYC_DESEL;
    else if (!strb_ctl_n) cyc = chip_sel ? CYC_START_CTL : CYC_DESEL;
    else if (!burst_adv_n) cyc = CYC_NEXT;
    else                  cyc = CYC_HOLD;
  end

  assign wr_req = write_active(wr_all_n, wr_lane_en_n, |(~lane_sel_n));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i] = !wr_all_n || (!wr_lane_en_n && !lane_sel_n[i]);
  end

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cyc_e               cyc,
  input  logic [ADDR_W-1:0]  ext_addr,
  input  logic               ilv_mode,
  output logic               acc_valid,
  output logic [ADDR_W-1:0]  acc_addr,
  output logic               burst_act,
  output logic [BURST_W-1:0] burst_step
);

  localparam int HI_W = ADDR_W - BURST_W;

  logic               act_q;
  logic [HI_W-1:0]    hi_q;
  logic [BURST_W-1:0] first_q;
  logic [BURST_W-1:0] step_q;
  logic [BURST_W-1:0] step_nx;
  logic               ilv_q;

  always_comb begin
    acc_valid = 1'b0;
    acc_addr  = ext_addr;
    step_nx   = step_q;
    case (cyc)
      CYC_START_CPU, CYC_START_CTL: begin
        acc_valid = 1'b1;
        acc_addr  = ext_addr;
      end
      CYC_NEXT: if (act_q) begin
        step_nx   = step_q + 1'b1;
        acc_valid = 1'b1;
        acc_addr  = {hi_q, burst_lo(first_q, step_nx, ilv_q)};
      end
      CYC_HOLD: if (act_q) begin
        acc_valid = 1'b1;
        acc_addr  = {hi_q, burst_lo(first_q, step_q, ilv_q)};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      hi_q    <= '0;
      first_q <= '0;
      step_q  <= '0;
      ilv_q   <= 1'b0;
    end else begin
      case (cyc)
        CYC_START_CPU, CYC_START_CTL: begin
          act_q   <= 1'b1;
          hi_q    <= ext_addr[ADDR_W-1:BURST_W];
          first_q <= ext_addr[BURST_W-1:0];
          step_q  <= '0;
          ilv_q   <= ilv_mode;
        end
        CYC_NEXT:             step_q <= step_nx;
        CYC_DESEL, CYC_SLEEP: act_q  <= 1'b0;
        default: ;
      endcase
    end
  end

  assign burst_act  = act_q;
  assign burst_step = step_q;

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [LANES-1:0]         lane_we,
  input  logic [ADDR_W-1:0]        waddr,
  input  logic [LANES*LANE_W-1:0]  wdata,
  input  logic [ADDR_W-1:0]        raddr,
  output logic [LANES*LANE_W-1:0]  rdata_q
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int i = 0; i < LANES; i++) begin
        if (lane_we[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= mem[raddr];
  end

endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pwr_dn,
  input  logic                    ce_pri_n,
  input  logic                    ce_hi,
  input  logic                    ce_lo_n,
  input  logic                    strb_cpu_n,
  input  logic                    strb_ctl_n,
  input  logic                    burst_adv_n,
  input  logic                    wr_all_n,
  input  logic                    wr_lane_en_n,
  input  logic [LANES-1:0]        lane_sel_n,
  input  logic                    oe_n,
  input  logic                    ilv_mode,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dq_oe
);

  cyc_e               cyc;
  logic               wr_req;
  logic [LANES-1:0]   lane_we;
  logic               acc_valid;
  logic [ADDR_W-1:0]  acc_addr;
  logic               burst_act;
  logic [BURST_W-1:0] burst_step;
  logic               acc_rd;
  logic               mem_we;
  logic               rd_pend_q;
  logic [ADDR_W-1:0]  rd_addr_q;
  logic               out_rd_q;
  logic               wr_q;

  sbsram_decode #(.LANES(LANES)) u_dec (
    .pwr_dn      (pwr_dn),
    .ce_pri_n    (ce_pri_n),
    .ce_hi       (ce_hi),
    .ce_lo_n     (ce_lo_n),
    .strb_cpu_n  (strb_cpu_n),
    .strb_ctl_n  (strb_ctl_n),
    .burst_adv_n (burst_adv_n),
    .wr_all_n    (wr_all_n),
    .wr_lane_en_n(wr_lane_en_n),
    .lane_sel_n  (lane_sel_n),
    .cyc         (cyc),
    .wr_req      (wr_req),
    .lane_we     (lane_we)
  );

  sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc       (cyc),
    .ext_addr  (addr),
    .ilv_mode  (ilv_mode),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .burst_act (burst_act),
    .burst_step(burst_step)
  );

  // A processor-strobe start is always a read.
  assign acc_rd = acc_valid && ((cyc == CYC_START_CPU) || !wr_req);
  assign mem_we = acc_valid && (cyc != CYC_START_CPU) && wr_req;

  sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (mem_we),
    .lane_we(lane_we),
    .waddr  (acc_addr),
    .wdata  (din),
    .raddr  (rd_addr_q),
    .rdata_q(dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
      out_rd_q  <= 1'b0;
      wr_q      <= 1'b0;
    end else begin
      rd_pend_q <= acc_rd;
      if (acc_rd) rd_addr_q <= acc_addr;
      out_rd_q  <= rd_pend_q && !pwr_dn;
      wr_q      <= mem_we;
    end
  end

  // Output enable acts without a clock; writes and power-down mask it.
  assign dq_oe = out_rd_q && !wr_q && !oe_n && !pwr_dn;

endmodule

// File: rtl/sbsram_ctrl_chk.sv
module sbsram_ctrl_chk
  import sbsram_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               pwr_dn,
  input logic               oe_n,
  input logic               ce_pri_n,
  input logic               strb_cpu_n,
  input logic               strb_ctl_n,
  input logic               dq_oe,
  input logic               mem_we,
  input logic               acc_valid,
  input cyc_e               cyc,
  input logic               burst_act,
  input logic [BURST_W-1:0] burst_step
);

  a_r1_sleep_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> !dq_oe);

  a_r1_sleep_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> !mem_we);

  a_r2_ce1_blocks_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_pri_n && !strb_ctl_n && !pwr_dn) |-> (!mem_we && !acc_valid));

  a_r4_cpu_start_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_pri_n && !strb_cpu_n) |-> !mem_we);

  a_r9_hold_keeps_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_HOLD) |=> $stable(burst_step));

  a_r11_oe_high_floats: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);

  a_r11_write_masks: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !dq_oe);

  a_r12_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (((cyc == CYC_NEXT) || (cyc == CYC_HOLD)) && !burst_act) |-> !acc_valid);

endmodule

bind sbsram_ctrl sbsram_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwr_dn    (pwr_dn),
  .oe_n      (oe_n),
  .ce_pri_n  (ce_pri_n),
  .strb_cpu_n(strb_cpu_n),
  .strb_ctl_n(strb_ctl_n),
  .dq_oe     (dq_oe),
  .mem_we    (mem_we),
  .acc_valid (acc_valid),
  .cyc       (cyc),
  .burst_act (burst_act),
  .burst_step(burst_step)
);

// File: tb/test_sbsram_ctrl.sv
module test_sbsram_ctrl;

  localparam int K_CPU = 0, K_CTL = 1, K_NEXT = 2, K_NEXTP = 3, K_HOLD = 4,
                 K_DESEL = 5, K_DS_CE2 = 6, K_DS_CE3 = 7, K_DS_BOTH = 8, K_SLEEP = 9;

  logic        clk = 1'b0;
  logic        rst_n, pwr_dn, ce_pri_n, ce_hi, ce_lo_n, strb_cpu_n, strb_ctl_n;
  logic        burst_adv_n, wr_all_n, wr_lane_en_n, oe_n, ilv_mode;
  logic [3:0]  lane_sel_n;
  logic [5:0]  addr;
  logic [31:0] din, dout;
  logic        dq_oe;

  sbsram_ctrl i_sbsram_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .ce_pri_n(ce_pri_n), .ce_hi(ce_hi),
    .ce_lo_n(ce_lo_n), .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n),
    .burst_adv_n(burst_adv_n), .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n),
    .lane_sel_n(lane_sel_n), .oe_n(oe_n), .ilv_mode(ilv_mode), .addr(addr),
    .din(din), .dout(dout), .dq_oe(dq_oe)
  );

  always #4 clk = ~clk;

  int n_pos = 0;
  always @(posedge clk) n_pos <= n_pos + 1;

  typedef struct {
    int          due;
    bit          drive;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] m_mem [64];
  bit          b_act = 0;
  bit          b_ilv = 0;
  int          b_hi = 0, b_first = 0, b_k = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input int due, input bit drv, input logic [31:0] d, input string tag);
    exp_t it;
    it.due = due; it.drive = drv; it.data = d; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic mask_prev(input int due);
    if (sb.size() > 0 && sb[$].due == due) sb[$].drive = 1'b0;
  endtask

  function automatic int burst_word();
    int lo;
    if (b_ilv) lo = b_first ^ b_k;
    else       lo = (b_first + b_k) % 4;
    return b_hi * 4 + lo;
  endfunction

  task automatic op(input int kind, input int a, input bit il, input bit g, input bit bw,
                    input logic [3:0] be, input logic [31:0] d, input string tag);
    int e;
    int acc;
    bit wr;
    bit isw;
    e   = n_pos + 1;
    acc = -1;
    isw = 0;
    wr  = !g || (!bw && be != 4'hF);
    pwr_dn = 0; ce_pri_n = 0; ce_hi = 1; ce_lo_n = 0;
    strb_cpu_n = 1; strb_ctl_n = 1; burst_adv_n = 1;
    wr_all_n = g; wr_lane_en_n = bw; lane_sel_n = be;
    addr = a[5:0]; din = d; ilv_mode = il;
    case (kind)
      K_CPU, K_CTL: begin
        if (kind == K_CPU) strb_cpu_n = 0;
        else               strb_ctl_n = 0;
        b_act = 1; b_hi = a / 4; b_first = a % 4; b_k = 0; b_ilv = il;
        acc = a;
        isw = (kind == K_CTL) && wr;
      end
      K_NEXT, K_NEXTP: begin
        ce_pri_n = 1; burst_adv_n = 0;
        if (kind == K_NEXTP) strb_cpu_n = 0;
        if (b_act) begin b_k = (b_k + 1) % 4; acc = burst_word(); isw = wr; end
      end
      K_HOLD: begin
        ce_pri_n = 1;
        if (b_act) begin acc = burst_word(); isw = wr; end
      end
      K_DESEL:   begin ce_pri_n = 1; strb_ctl_n = 0; b_act = 0; end
      K_DS_CE2:  begin strb_cpu_n = 0; ce_hi = 0; b_act = 0; end
      K_DS_CE3:  begin strb_ctl_n = 0; ce_lo_n = 1; b_act = 0; end
      K_DS_BOTH: begin ce_pri_n = 1; strb_cpu_n = 0; strb_ctl_n = 0; b_act = 0; end
      K_SLEEP:   begin pwr_dn = 1; ce_pri_n = 1; burst_adv_n = 0; b_act = 0; mask_prev(e); end
      default: ;
    endcase
    if (acc >= 0 && isw) begin
      for (int i = 0; i < 4; i++)
        if (!g || !be[i]) m_mem[acc][i*8 +: 8] = d[i*8 +: 8];
      mask_prev(e);
      push(e + 1, 1'b0, 32'h0, tag);
    end else if (acc >= 0) begin
      push(e + 1, 1'b1, m_mem[acc], tag);
    end else begin
      push(e + 1, 1'b0, 32'h0, tag);
    end
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic wr_all(input int kind, input int a, input logic [31:0] d, input string tag);
    op(kind, a, 1'b0, 1'b0, 1'b1, 4'hF, d, tag);
  endtask

  task automatic rd(input int kind, input int a, input bit il, input string tag);
    op(kind, a, il, 1'b1, 1'b1, 4'hF, 32'hDEAD_BEEF, tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Monitor: compare the bus at the negative edge that each item is due.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].due <= n_pos) begin
        exp_t it;
        it = sb.pop_front();
        if (it.due != n_pos) begin
          check(1'b0, {it.tag, " slot"}, n_pos, it.due);
        end else begin
          check(dq_oe == it.drive, {it.tag, " drive"}, {31'b0, dq_oe}, {31'b0, it.drive});
          if (it.drive) check(dout == it.data, {it.tag, " data"}, dout, it.data);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; pwr_dn = 0; ce_pri_n = 1; ce_hi = 1; ce_lo_n = 0;
    strb_cpu_n = 1; strb_ctl_n = 0; burst_adv_n = 1; wr_all_n = 1; wr_lane_en_n = 1;
    lane_sel_n = 4'hF; oe_n = 0; ilv_mode = 0; addr = 0; din = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    check(dq_oe == 1'b0, "R12 reset bus released", {31'b0, dq_oe}, 32'h0);

    // R12: advance and hold with no open burst after reset
    wr_all(K_NEXT, 0, 32'h0BAD_0001, "R12 advance after reset");
    rd(K_HOLD, 0, 0, "R12 hold after reset");

    // R5/R7: controller-strobe write bursts, linear, incl. wrap
    wr_all(K_CTL, 8, 32'hA000_0008, "R5 ctl write start");
    wr_all(K_NEXT, 0, 32'hA000_0009, "R7 linear write");
    wr_all(K_NEXT, 0, 32'hA000_000A, "R7 linear write");
    wr_all(K_NEXT, 0, 32'hA000_000B, "R7 linear write");
    wr_all(K_CTL, 14, 32'hB000_000E, "R5 ctl write start");
    wr_all(K_NEXT, 0, 32'hB000_000F, "R7 linear wrap write");
    wr_all(K_NEXT, 0, 32'hB000_000C, "R7 linear wrap write");
    wr_all(K_NEXT, 0, 32'hB000_000D, "R7 linear wrap write");

    // R4/R7/R10: processor-strobe read bursts
    rd(K_CPU, 8, 0, "R10 cpu read start");
    rd(K_NEXT, 0, 0, "R7 linear read");
    rd(K_NEXT, 0, 0, "R7 linear read");
    rd(K_NEXT, 0, 0, "R7 linear read");
    rd(K_CPU, 14, 0, "R4 cpu read start");
    rd(K_NEXT, 0, 0, "R7 wrap read");
    rd(K_NEXT, 0, 0, "R7 wrap read");
    rd(K_NEXT, 0, 0, "R7 wrap read");

    // R8: interleaved order
    wr_all(K_CTL, 33, 32'hC000_0021, "R5 ctl write start");
    wr_all(K_NEXT, 0, 32'hC000_0022, "R7 linear write");
    wr_all(K_NEXT, 0, 32'hC000_0023, "R7 linear write");
    wr_all(K_NEXT, 0, 32'hC000_0020, "R7 linear write");
    rd(K_CPU, 33, 1, "R8 interleaved start");
    rd(K_NEXT, 0, 1, "R8 interleaved read");
    rd(K_NEXT, 0, 1, "R8 interleaved read");
    rd(K_NEXT, 0, 1, "R8 interleaved read");

    // R9: hold reuses the address for reads and writes
    rd(K_CPU, 9, 0, "R9 read start");
    rd(K_HOLD, 0, 0, "R9 hold read");
    rd(K_HOLD, 0, 0, "R9 hold read");
    wr_all(K_CTL, 16, 32'hD000_0010, "R5 ctl write start");
    wr_all(K_HOLD, 0, 32'h5A5A_5A5A, "R9 hold write");
    wr_all(K_NEXT, 0, 32'hD000_0011, "R7 linear write");
    rd(K_CPU, 16, 0, "R9 read back hold write");
    rd(K_NEXT, 0, 0, "R9 read back next");

    // R6: lane writes and combined write
    op(K_CTL, 16, 0, 1'b1, 1'b0, 4'b1010, 32'h1122_3344, "R6 lanes 0 and 2");
    op(K_CTL, 16, 0, 1'b1, 1'b0, 4'b1111, 32'hFFFF_FFFF, "R6 no lane is read");
    op(K_CTL, 17, 0, 1'b1, 1'b1, 4'b0000, 32'hFFFF_FFFF, "R6 lane enable off is read");
    rd(K_CPU, 16, 0, "R6 merged lanes");

    // R4: processor strobe with global write still reads
    wr_all(K_CPU, 8, 32'hEEEE_EEEE, "R4 cpu strobe with write");
    rd(K_CPU, 8, 0, "R4 location unchanged");

    // R5/R11: write on the edge after a processor-strobe read; write masks bus
    rd(K_CPU, 20, 0, "R11 read before write");
    wr_all(K_NEXT, 0, 32'hF000_0015, "R5 write after cpu start");
    rd(K_CPU, 21, 0, "R5 read back");
    rd(K_CPU, 9, 0, "R11 read before ctl write");
    wr_all(K_CTL, 22, 32'hF000_0016, "R11 ctl write masks");
    rd(K_CPU, 22, 0, "R5 read back");

    // R2/R3: deselects
    rd(K_DS_CE2, 8, 0, "R3 ce2 low deselect");
    wr_all(K_DS_CE3, 8, 32'h0BAD_0002, "R3 ce3 high deselect");
    wr_all(K_DS_BOTH, 8, 32'h0BAD_0003, "R2 ce1 high deselect");
    rd(K_CPU, 8, 0, "R2 R3 no write happened");
    rd(K_CPU, 10, 0, "R2 read start");
    rd(K_NEXTP, 0, 0, "R2 cpu strobe ignored");

    // R12: after a deselect, advance and hold make no access
    rd(K_DESEL, 0, 0, "R12 deselect");
    wr_all(K_NEXT, 0, 32'h0BAD_0004, "R12 advance no burst");
    rd(K_HOLD, 0, 0, "R12 hold no burst");
    rd(K_CPU, 8, 0, "R12 first word intact");
    rd(K_NEXT, 0, 0, "R12 next word intact");

    // R1: power-down
    rd(K_CPU, 12, 0, "R1 read before sleep");
    wr_all(K_SLEEP, 0, 32'h0BAD_0005, "R1 sleep");
    wr_all(K_NEXT, 0, 32'h0BAD_0006, "R1 burst closed by sleep");
    rd(K_CPU, 13, 0, "R1 no write in sleep");
    rd(K_CPU, 12, 0, "R1 no write in sleep");

    // R11: output enable acts without a clock
    rd(K_CPU, 8, 0, "R11 read for oe");
    rd(K_DESEL, 0, 0, "R11 deselect");
    check(dq_oe == 1'b1, "R11 drive with oe low", {31'b0, dq_oe}, 32'h1);
    check(dout == 32'hA000_0008, "R10 data held", dout, 32'hA000_0008);
    oe_n = 1;
    #1;
    check(dq_oe == 1'b0, "R11 oe high releases", {31'b0, dq_oe}, 32'h0);
    oe_n = 0;
    #1;
    check(dq_oe == 1'b1, "R11 oe low drives again", {31'b0, dq_oe}, 32'h1);

    rd(K_DESEL, 0, 0, "R12 idle");
    rd(K_DESEL, 0, 0, "R12 idle");
    rd(K_DESEL, 0, 0, "R12 idle");
    while (sb.size() > 0) @(negedge clk);
    #1;
    summary();
    $finish;
  end

endmodule